// File: doc/BRIEF.md
# Two-Way Set-Associative Data Cache

This block is a data cache placed between a processor's load/store request port and a slower main-memory port. Storage is grouped into sets, and each set holds two lines. A line carries a 4-byte block, a tag, a valid flag and a dirty flag. A byte address is split, from the top bit down, into a tag, a set index and a 2-bit byte offset. A request is served directly when either line of its set holds a matching tag. Otherwise, a victim is chosen inside the set using a single least-recently-used bit. A dirty victim is copied back to memory first. The line is then refilled from memory, and only after that is the request completed.

Two mode inputs are sampled when a request is accepted. With `mode_wthru` low, writes stay in the cache and mark the line dirty. With it high, every write is also forwarded to memory as a full merged block, and the line stays clean. Raising `cache_off` sends the access straight to memory and leaves the cached lines untouched. Only one request is outstanding at a time. The processor holds `cpu_req` and its operands until `cpu_ready` pulses.

Top module: `duo_way_cache`

## Requirements
- R1: After reset every line is invalid, `cpu_ready` and `mem_req` are low, and the first access to any address is a miss that fetches from memory.
- R2: The tag is `cpu_addr[ADDR_W-1:SET_W+2]`, the set index is `cpu_addr[SET_W+1:2]`, and `cpu_addr[1:0]` does not take part in lookup. With `SET_W` = 13 this gives a 9/13/2 split of a 24-bit address. Every memory address issued has its low two bits at zero.
- R3: A request whose tag matches a valid line in either way of its set completes with no memory transaction. At most one way matches.
- R4: A read miss performs one full-block memory read (all four byte strobes set) of the requested block. The read data is returned to the processor only after `mem_ack`. `cpu_ready` is never high while `mem_req` is high.
- R5: On a miss, the victim is way 0 if it is invalid, else way 1 if it is invalid, else the way used less recently. Every hit and every fill marks the accessed way as the most recently used.
- R6: In write-back mode, a write hit changes only the cache line and sets its dirty flag. No memory transaction occurs.
- R7: A dirty victim is written back as one full-block write to its own address, before the refill read. A clean victim causes no memory write.
- R8: A write miss allocates the line. The block is fetched, and then the bytes with `cpu_be[i]` set replace bits `8*i+7:8*i`. In write-back mode the line is marked dirty, and memory is not updated until eviction.
- R9: In write-through mode, each write (hit or miss) produces exactly one full-block memory write of the merged line, after any refill. The line is left clean, so a later eviction writes nothing.
- R10: With `cache_off` high, each access is exactly one memory transaction. It carries the processor's write flag, byte strobes (all set for reads) and write data. No line is allocated or modified.
- R11: `cpu_ready` is a one-cycle pulse. `mem_req` stays high with a stable address and write flag until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_be | input | 4 | Byte strobes for writes; bit i selects byte i |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 32 | Write data |
| mode_wthru | input | 1 | 1 = write-through, 0 = write-back |
| cache_off | input | 1 | 1 = bypass the cache |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ready` on a read |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | Memory write flag |
| mem_be | output | 4 | Memory byte strobes |
| mem_addr | output | ADDR_W | Block-aligned memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | One-cycle completion from memory |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |

## Verification
The hardest overlap is a write miss that lands on a set whose least-recently-used line is dirty. In that case the eviction copy-back and the write-allocate merge take place within one request. In the same cycle as the refill, the fill also rewrites the dirty flag and moves the LRU bit. The bench provokes this by dirtying one way of a set, touching the other way, and then writing a new tag with partial byte strobes. It judges the result in three ways: memory must hold the old dirty data at the victim's address, a readback must return the fetched block with only the strobed bytes replaced, and a later eviction must copy the merged block out.

// File: rtl/dcache_pkg.sv
package dcache_pkg;

    localparam int BYTE_W    = 8;
    localparam int BLK_BYTES = 4;
    localparam int BLK_W     = BYTE_W * BLK_BYTES;
    localparam int OFF_W     = $clog2(BLK_BYTES);

    typedef logic [BLK_W-1:0]     blk_t;
    typedef logic [BLK_BYTES-1:0] bmask_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_WRBACK,
        ST_REFILL,
        ST_THROUGH,
        ST_BYPASS,
        ST_RESPOND
    } dc_state_e;

    typedef struct packed {
        logic   we;
        logic   thru;
        logic   off;
        bmask_t be;
        blk_t   wdata;
    } dc_req_t;

    // Replace the strobed bytes of a block.
    function automatic blk_t merge_bytes(blk_t old_b, blk_t new_b, bmask_t be);
        blk_t res;
        res = old_b;
        for (int i = 0; i < BLK_BYTES; i++) begin
            if (be[i]) res[i*BYTE_W +: BYTE_W] = new_b[i*BYTE_W +: BYTE_W];
        end
        return res;
    endfunction

endpackage

// File: rtl/dc_store.sv
module dc_store
    import dcache_pkg::*;
#(
    parameter int SET_W = 8,
    parameter int TAG_W = 14
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [SET_W-1:0]      rd_set,
    output logic [1:0][TAG_W-1:0] rd_tag,
    output logic [1:0]            rd_valid,
    output logic [1:0]            rd_dirty,
    output blk_t [1:0]            rd_data,
    input  logic                  wr_en,
    input  logic                  wr_way,
    input  logic [SET_W-1:0]      wr_set,
    input  logic [TAG_W-1:0]      wr_tag,
    input  logic                  wr_dirty,
    input  blk_t                  wr_data
);

    localparam int SETS = 1 << SET_W;

    for (genvar w = 0; w < 2; w++) begin : g_way
        logic [TAG_W-1:0] tag_mem  [SETS];
        blk_t             data_mem [SETS];
        logic [SETS-1:0]  vld_q;
        logic [SETS-1:0]  drt_q;
        logic             sel;

        assign sel = wr_en && (wr_way == 1'(w));

        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q <= '0;
                drt_q <= '0;
            end else if (sel) begin
                vld_q[wr_set] <= 1'b1;
                drt_q[wr_set] <= wr_dirty;
            end
        end

        always_ff @(posedge clk) begin
            if (sel) begin
                tag_mem[wr_set]  <= wr_tag;
                data_mem[wr_set] <= wr_data;
            end
        end

        assign rd_tag[w]   = tag_mem[rd_set];
        assign rd_data[w]  = data_mem[rd_set];
        assign rd_valid[w] = vld_q[rd_set];
        assign rd_dirty[w] = drt_q[rd_set];
    end

endmodule

// File: rtl/dc_lru.sv
module dc_lru #(
    parameter int SET_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SET_W-1:0] rd_set,
    output logic             rd_old_way,
    input  logic             upd_en,
    input  logic [SET_W-1:0] upd_set,
    input  logic             upd_used_way
);

    localparam int SETS = 1 << SET_W;

    // One bit per set naming the way touched less recently.
    logic [SETS-1:0] old_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            old_q <= '0;
        end else if (upd_en) begin
            old_q[upd_set] <= ~upd_used_way;
        end
    end

    assign rd_old_way = old_q[rd_set];

endmodule

// File: rtl/dc_match.sv
module dc_match #(
    parameter int TAG_W = 14
) (
    input  logic [1:0][TAG_W-1:0] way_tag,
    input  logic [1:0]            way_valid,
    input  logic [TAG_W-1:0]      req_tag,
    input  logic                  old_way,
    output logic [1:0]            hit_vec,
    output logic                  hit,
    output logic                  hit_way,
    output logic                  victim_way
);

    for (genvar w = 0; w < 2; w++) begin : g_cmp
        assign hit_vec[w] = way_valid[w] && (way_tag[w] == req_tag);
    end

    assign hit     = |hit_vec;
    assign hit_way = hit_vec[1];

    always_comb begin
        if (!way_valid[0])      victim_way = 1'b0;
        else if (!way_valid[1]) victim_way = 1'b1;
        else                    victim_way = old_way;
    end

endmodule

// File: rtl/dc_ctrl.sv
module dc_ctrl
    import dcache_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int SET_W  = 8,
    parameter int TAG_W  = 14
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cpu_req,
    input  logic                  cpu_we,
    input  bmask_t                cpu_be,
    input  logic [ADDR_W-1:0]     cpu_addr,
    input  blk_t                  cpu_wdata,
    input  logic                  mode_wthru,
    input  logic                  cache_off,
    output logic                  cpu_ready,
    output blk_t                  cpu_rdata,
    output logic                  mem_req,
    output logic                  mem_we,
    output bmask_t                mem_be,
    output logic [ADDR_W-1:0]     mem_addr,
    output blk_t                  mem_wdata,
    input  logic                  mem_ack,
    input  blk_t                  mem_rdata,
    output logic [SET_W-1:0]      look_set,
    output logic [TAG_W-1:0]      look_tag,
    input  logic [1:0][TAG_W-1:0] way_tag,
    input  logic [1:0]            way_valid,
    input  logic [1:0]            way_dirty,
    input  blk_t [1:0]            way_data,
    input  logic                  hit,
    input  logic                  hit_way,
    input  logic                  victim_way,
    output logic                  st_wr_en,
    output logic                  st_wr_way,
    output logic [TAG_W-1:0]      st_wr_tag,
    output logic                  st_wr_dirty,
    output blk_t                  st_wr_data,
    output logic                  lru_upd,
    output logic                  lru_used,
    output dc_state_e             cur_state,
    output logic                  cur_thru
);

    localparam logic [OFF_W-1:0] OFF_ZERO = '0;

    dc_state_e        state_q;
    logic [SET_W-1:0] set_q;
    logic [TAG_W-1:0] tag_q;
    logic [TAG_W-1:0] vtag_q;
    dc_req_t          req_q;
    logic             way_q;
    blk_t             line_q;
    blk_t             rdata_q;

    blk_t      hit_data;
    blk_t      hit_merge;
    blk_t      fill_merge;
    logic      victim_dirty;
    logic      fill_done;
    dc_state_e after_fill;

    assign hit_data     = way_data[hit_way];
    assign hit_merge    = merge_bytes(hit_data, req_q.wdata, req_q.be);
    assign fill_merge   = req_q.we ? merge_bytes(mem_rdata, req_q.wdata, req_q.be) : mem_rdata;
    assign victim_dirty = way_valid[victim_way] && way_dirty[victim_way];
    assign fill_done    = (state_q == ST_REFILL) && mem_ack;
    assign after_fill   = (req_q.we && req_q.thru) ? ST_THROUGH : ST_RESPOND;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            set_q   <= '0;
            tag_q   <= '0;
            vtag_q  <= '0;
            req_q   <= '0;
            way_q   <= 1'b0;
            line_q  <= '0;
            rdata_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (cpu_req) begin
                        set_q       <= cpu_addr[OFF_W +: SET_W];
                        tag_q       <= cpu_addr[ADDR_W-1 -: TAG_W];
                        req_q.we    <= cpu_we;
                        req_q.thru  <= mode_wthru;
                        req_q.off   <= cache_off;
                        req_q.be    <= cpu_we ? cpu_be : '1;
                        req_q.wdata <= cpu_wdata;
                        state_q     <= cache_off ? ST_BYPASS : ST_LOOKUP;
                    end
                end
                ST_LOOKUP: begin
                    if (hit) begin
                        way_q   <= hit_way;
                        rdata_q <= hit_data;
                        line_q  <= hit_merge;
                        state_q <= (req_q.we && req_q.thru) ? ST_THROUGH : ST_RESPOND;
                    end else begin
                        way_q   <= victim_way;
                        vtag_q  <= way_tag[victim_way];
                        line_q  <= way_data[victim_way];
                        state_q <= victim_dirty ? ST_WRBACK : ST_REFILL;
                    end
                end
                ST_WRBACK: begin
                    if (mem_ack) state_q <= ST_REFILL;
                end
                ST_REFILL: begin
                    if (mem_ack) begin
                        rdata_q <= mem_rdata;
                        line_q  <= fill_merge;
                        state_q <= after_fill;
                    end
                end
                ST_THROUGH: begin
                    if (mem_ack) state_q <= ST_RESPOND;
                end
                ST_BYPASS: begin
                    if (mem_ack) begin
                        if (!req_q.we) rdata_q <= mem_rdata;
                        state_q <= ST_RESPOND;
                    end
                end
                ST_RESPOND: state_q <= ST_IDLE;
                default:    state_q <= ST_IDLE;
            endcase
        end
    end

    // Store and LRU update.
    assign look_set    = set_q;
    assign look_tag    = tag_q;
    assign st_wr_en    = ((state_q == ST_LOOKUP) && hit && req_q.we) || fill_done;
    assign st_wr_way   = (state_q == ST_LOOKUP) ? hit_way : way_q;
    assign st_wr_tag   = tag_q;
    assign st_wr_dirty = req_q.we && !req_q.thru;
    assign st_wr_data  = (state_q == ST_LOOKUP) ? hit_merge : fill_merge;
    assign lru_upd     = ((state_q == ST_LOOKUP) && hit) || fill_done;
    assign lru_used    = st_wr_way;

    // Memory port.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_be    = '1;
        mem_addr  = {tag_q, set_q, OFF_ZERO};
        mem_wdata = line_q;
        case (state_q)
            ST_WRBACK: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = {vtag_q, set_q, OFF_ZERO};
            end
            ST_REFILL: begin
                mem_req = 1'b1;
            end
            ST_THROUGH: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            ST_BYPASS: begin
                mem_req   = 1'b1;
                mem_we    = req_q.we;
                mem_be    = req_q.be;
                mem_wdata = req_q.wdata;
            end
            default: ;
        endcase
    end

    assign cpu_ready = (state_q == ST_RESPOND);
    assign cpu_rdata = rdata_q;
    assign cur_state = state_q;
    assign cur_thru  = req_q.thru;

endmodule

// File: rtl/duo_way_cache.sv
module duo_way_cache
    import dcache_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int SET_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [3:0]        cpu_be,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [31:0]       cpu_wdata,
    input  logic              mode_wthru,
    input  logic              cache_off,
    output logic              cpu_ready,
    output logic [31:0]       cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [3:0]        mem_be,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata
);

    localparam int TAG_W = ADDR_W - SET_W - OFF_W;

    logic [SET_W-1:0]      look_set;
    logic [TAG_W-1:0]      look_tag;
    logic [1:0][TAG_W-1:0] way_tag;
    logic [1:0]            way_valid;
    logic [1:0]            way_dirty;
    blk_t [1:0]            way_data;
    logic                  old_way;
    logic [1:0]            hit_vec;
    logic                  hit;
    logic                  hit_way;
    logic                  victim_way;
    logic                  st_wr_en;
    logic                  st_wr_way;
    logic [TAG_W-1:0]      st_wr_tag;
    logic                  st_wr_dirty;
    blk_t                  st_wr_data;
    logic                  lru_upd;
    logic                  lru_used;
    dc_state_e             cur_state;
    logic                  cur_thru;

    dc_store #(.SET_W(SET_W), .TAG_W(TAG_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .rd_set   (look_set),
        .rd_tag   (way_tag),
        .rd_valid (way_valid),
        .rd_dirty (way_dirty),
        .rd_data  (way_data),
        .wr_en    (st_wr_en),
        .wr_way   (st_wr_way),
        .wr_set   (look_set),
        .wr_tag   (st_wr_tag),
        .wr_dirty (st_wr_dirty),
        .wr_data  (st_wr_data)
    );

    dc_lru #(.SET_W(SET_W)) u_lru (
        .clk          (clk),
        .rst          (rst),
        .rd_set       (look_set),
        .rd_old_way   (old_way),
        .upd_en       (lru_upd),
        .upd_set      (look_set),
        .upd_used_way (lru_used)
    );

    dc_match #(.TAG_W(TAG_W)) u_match (
        .way_tag    (way_tag),
        .way_valid  (way_valid),
        .req_tag    (look_tag),
        .old_way    (old_way),
        .hit_vec    (hit_vec),
        .hit        (hit),
        .hit_way    (hit_way),
        .victim_way (victim_way)
    );

    dc_ctrl #(.ADDR_W(ADDR_W), .SET_W(SET_W), .TAG_W(TAG_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .cpu_req     (cpu_req),
        .cpu_we      (cpu_we),
        .cpu_be      (cpu_be),
        .cpu_addr    (cpu_addr),
        .cpu_wdata   (cpu_wdata),
        .mode_wthru  (mode_wthru),
        .cache_off   (cache_off),
        .cpu_ready   (cpu_ready),
        .cpu_rdata   (cpu_rdata),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_be      (mem_be),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_ack     (mem_ack),
        .mem_rdata   (mem_rdata),
        .look_set    (look_set),
        .look_tag    (look_tag),
        .way_tag     (way_tag),
        .way_valid   (way_valid),
        .way_dirty   (way_dirty),
        .way_data    (way_data),
        .hit         (hit),
        .hit_way     (hit_way),
        .victim_way  (victim_way),
        .st_wr_en    (st_wr_en),
        .st_wr_way   (st_wr_way),
        .st_wr_tag   (st_wr_tag),
        .st_wr_dirty (st_wr_dirty),
        .st_wr_data  (st_wr_data),
        .lru_upd     (lru_upd),
        .lru_used    (lru_used),
        .cur_state   (cur_state),
        .cur_thru    (cur_thru)
    );

endmodule

// File: rtl/dc_checker.sv
module dc_checker
    import dcache_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_ready,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [3:0]        mem_be,
    input logic [ADDR_W-1:0] mem_addr,
    input dc_state_e         state,
    input logic              thru,
    input logic              st_wr_en,
    input logic              st_wr_dirty,
    input logic [1:0]        hit_vec
);

    assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!cpu_ready && !mem_req));

    assert_block_aligned_R2: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    assert_single_hit_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOOKUP) |-> $onehot0(hit_vec));

    assert_ready_after_mem_R4: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |-> !mem_req);

    assert_fetch_full_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |-> (mem_be == 4'hF));

    assert_thru_clean_R9: assert property (@(posedge clk) disable iff (rst)
        (st_wr_en && thru) |-> !st_wr_dirty);

    assert_bypass_no_alloc_R10: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BYPASS) |-> !st_wr_en);

    assert_ready_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |=> !cpu_ready);

    assert_mem_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

endmodule

bind duo_way_cache dc_checker #(.ADDR_W(ADDR_W)) u_dc_checker (
    .clk         (clk),
    .rst         (rst),
    .cpu_ready   (cpu_ready),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_ack     (mem_ack),
    .mem_be      (mem_be),
    .mem_addr    (mem_addr),
    .state       (cur_state),
    .thru        (cur_thru),
    .st_wr_en    (st_wr_en),
    .st_wr_dirty (st_wr_dirty),
    .hit_vec     (hit_vec)
);

// File: tb/duo_way_cache_bench.sv
`timescale 1ns/1ps
module duo_way_cache_bench;

    localparam int ADDR_W = 24;
    localparam int SET_W  = 2;
    localparam int LAT    = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cpu_req = 1'b0;
    logic              cpu_we = 1'b0;
    logic [3:0]        cpu_be = 4'h0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [31:0]       cpu_wdata = '0;
    logic              mode_wthru = 1'b0;
    logic              cache_off = 1'b0;
    logic              cpu_ready;
    logic [31:0]       cpu_rdata;
    logic              mem_req;
    logic              mem_we;
    logic [3:0]        mem_be;
    logic [ADDR_W-1:0] mem_addr;
    logic [31:0]       mem_wdata;
    logic              mem_ack;
    logic [31:0]       mem_rdata;

    always #4 clk = ~clk;

    duo_way_cache #(.ADDR_W(ADDR_W), .SET_W(SET_W)) u_duo_way_cache (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_be(cpu_be),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .mode_wthru(mode_wthru),
        .cache_off(cache_off), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_be(mem_be), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int n_chk  = 0;
    int n_fail = 0;

    logic [31:0]       mem_m [64];
    logic [31:0]       ref_m [64];
    int                rd_cnt;
    int                wr_cnt;
    int                lat_cnt;
    logic [ADDR_W-1:0] last_wr_addr;
    logic [3:0]        last_wr_be;

    function automatic logic [31:0] pat(int i);
        return (32'(i) * 32'h0001_0107) ^ 32'hA5C3_0000;
    endfunction

    function automatic logic [31:0] mrg(logic [31:0] o, logic [31:0] n, logic [3:0] be);
        logic [31:0] r;
        r = o;
        for (int i = 0; i < 4; i++) if (be[i]) r[i*8 +: 8] = n[i*8 +: 8];
        return r;
    endfunction

    function automatic logic [ADDR_W-1:0] ad(int t, int s);
        return ADDR_W'((t << 4) | (s << 2));
    endfunction

    function automatic int ix(int t, int s);
        return t * 4 + s;
    endfunction

    // Memory model with fixed latency.
    always @(posedge clk) begin
        if (rst) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
            lat_cnt   <= 0;
            rd_cnt    <= 0;
            wr_cnt    <= 0;
            last_wr_addr <= '0;
            last_wr_be   <= '0;
            for (int i = 0; i < 64; i++) mem_m[i] <= pat(i);
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req) begin
            if (lat_cnt == LAT - 1) begin
                lat_cnt <= 0;
                mem_ack <= 1'b1;
                if (mem_we) begin
                    mem_m[mem_addr[7:2]] <= mrg(mem_m[mem_addr[7:2]], mem_wdata, mem_be);
                    wr_cnt       <= wr_cnt + 1;
                    last_wr_addr <= mem_addr;
                    last_wr_be   <= mem_be;
                end else begin
                    mem_rdata <= mem_m[mem_addr[7:2]];
                    rd_cnt    <= rd_cnt + 1;
                end
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end
    end

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic do_op(input logic we, input logic [ADDR_W-1:0] a, input logic [3:0] be,
                         input logic [31:0] wd, output logic [31:0] rd, output int nr, output int nw);
        int r0;
        int w0;
        r0 = rd_cnt;
        w0 = wr_cnt;
        @(negedge clk);
        cpu_req   = 1'b1;
        cpu_we    = we;
        cpu_addr  = a;
        cpu_be    = be;
        cpu_wdata = wd;
        @(negedge clk);
        while (!cpu_ready) @(negedge clk);
        rd = cpu_rdata;
        cpu_req = 1'b0;
        nr = rd_cnt - r0;
        nw = wr_cnt - w0;
        if (we) ref_m[a[7:2]] = mrg(ref_m[a[7:2]], wd, be);
        @(negedge clk);
        chk("R11", "ready pulse width", {31'd0, cpu_ready}, 32'd0);
    endtask

    task automatic rd_exp(input int t, input int s, input int enr, input int enw, input string rq);
        logic [31:0] rd;
        int nr;
        int nw;
        do_op(1'b0, ad(t, s), 4'h0, 32'h0, rd, nr, nw);
        chk(rq, $sformatf("read data t%0d s%0d", t, s), rd, ref_m[ix(t, s)]);
        chk(rq, $sformatf("read count t%0d s%0d", t, s), 32'(nr), 32'(enr));
        chk(rq, $sformatf("write count t%0d s%0d", t, s), 32'(nw), 32'(enw));
    endtask

    task automatic wr_exp(input int t, input int s, input logic [3:0] be, input logic [31:0] wd,
                          input int enr, input int enw, input string rq);
        logic [31:0] rd;
        int nr;
        int nw;
        do_op(1'b1, ad(t, s), be, wd, rd, nr, nw);
        chk(rq, $sformatf("wr read count t%0d s%0d", t, s), 32'(nr), 32'(enr));
        chk(rq, $sformatf("wr write count t%0d s%0d", t, s), 32'(nw), 32'(enw));
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        int nr;
        int nw;
        for (int i = 0; i < 64; i++) ref_m[i] = pat(i);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "ready after reset", {31'd0, cpu_ready}, 32'd0);
        chk("R1", "mem_req after reset", {31'd0, mem_req}, 32'd0);

        // R1 R4: cold misses, one fill each.
        for (int s = 0; s < 4; s++)
            for (int t = 0; t < 2; t++) rd_exp(t, s, 1, 0, "R4");
        // R2 R3: offset bits ignored, both ways hit.
        for (int s = 0; s < 4; s++)
            for (int t = 0; t < 2; t++) begin
                do_op(1'b0, ad(t, s) | 24'h3, 4'h0, 32'h0, rd, nr, nw);
                chk("R2", "offset hit data", rd, ref_m[ix(t, s)]);
                chk("R3", "hit no traffic", 32'(nr + nw), 32'd0);
            end

        // R5: LRU in set 0 (t0 least recent now).
        rd_exp(0, 0, 0, 0, "R5");
        rd_exp(2, 0, 1, 0, "R5");
        rd_exp(0, 0, 0, 0, "R5");
        rd_exp(1, 0, 1, 0, "R5");
        rd_exp(0, 0, 0, 0, "R5");

        // R6 R7: write-back hit, clean and dirty eviction in set 1.
        wr_exp(0, 1, 4'hF, 32'hDEAD_0001, 0, 0, "R6");
        chk("R6", "memory untouched by write hit", mem_m[ix(0, 1)], pat(ix(0, 1)));
        rd_exp(0, 1, 0, 0, "R6");
        rd_exp(2, 1, 1, 0, "R7");
        rd_exp(3, 1, 1, 1, "R7");
        chk("R7", "victim copied back", mem_m[ix(0, 1)], 32'hDEAD_0001);
        chk("R7", "copy-back address", 32'(last_wr_addr), 32'(ad(0, 1)));

        // R8 R7: write miss on dirty victim in set 2.
        wr_exp(1, 2, 4'hF, 32'hBEEF_0002, 0, 0, "R6");
        rd_exp(0, 2, 0, 0, "R5");
        wr_exp(4, 2, 4'b0110, 32'h1234_5678, 1, 1, "R8");
        chk("R7", "dirty victim data", mem_m[ix(1, 2)], 32'hBEEF_0002);
        chk("R7", "dirty victim address", 32'(last_wr_addr), 32'(ad(1, 2)));
        chk("R8", "allocated line not in memory", mem_m[ix(4, 2)], pat(ix(4, 2)));
        rd_exp(4, 2, 0, 0, "R8");
        chk("R8", "merged bytes", ref_m[ix(4, 2)], mrg(pat(ix(4, 2)), 32'h1234_5678, 4'b0110));
        rd_exp(5, 2, 1, 0, "R5");
        rd_exp(6, 2, 1, 1, "R8");
        chk("R8", "merged block evicted", mem_m[ix(4, 2)], mrg(pat(ix(4, 2)), 32'h1234_5678, 4'b0110));

        // R9: write-through in set 3.
        mode_wthru = 1'b1;
        wr_exp(0, 3, 4'hF, 32'hC0DE_0004, 0, 1, "R9");
        chk("R9", "through hit memory", mem_m[ix(0, 3)], 32'hC0DE_0004);
        chk("R9", "through strobes", {28'd0, last_wr_be}, 32'hF);
        wr_exp(5, 3, 4'b1000, 32'h7700_0000, 1, 1, "R9");
        chk("R9", "through miss memory", mem_m[ix(5, 3)], mrg(pat(ix(5, 3)), 32'h7700_0000, 4'b1000));
        mode_wthru = 1'b0;
        rd_exp(6, 3, 1, 0, "R9");
        rd_exp(7, 3, 1, 0, "R9");

        // R10: bypass.
        cache_off = 1'b1;
        rd_exp(8, 0, 1, 0, "R10");
        rd_exp(8, 0, 1, 0, "R10");
        wr_exp(8, 0, 4'b0011, 32'h0000_ABCD, 0, 1, "R10");
        chk("R10", "bypass strobes", {28'd0, last_wr_be}, 32'h3);
        chk("R10", "bypass memory", mem_m[ix(8, 0)], mrg(pat(ix(8, 0)), 32'h0000_ABCD, 4'b0011));
        rd_exp(8, 0, 1, 0, "R10");
        cache_off = 1'b0;
        rd_exp(8, 0, 1, 0, "R10");
        rd_exp(8, 0, 0, 0, "R3");

        // Mixed sweep over 4 sets x 8 tags, both write modes.
        for (int k = 0; k < 160; k++) begin
            int t;
            int s;
            logic we;
            logic [3:0] be;
            t = (k * 5 + k / 8) % 8;
            s = (k * 3) % 4;
            we = (k % 3 == 1);
            be = 4'((k * 7) % 15 + 1);
            mode_wthru = (k % 5 == 0);
            do_op(we, ad(t, s), be, 32'(k) * 32'h9E37_79B9, rd, nr, nw);
            if (!we) chk("R4", $sformatf("sweep read %0d", k), rd, ref_m[ix(t, s)]);
            else if (mode_wthru) chk("R9", $sformatf("sweep through write %0d", k), {31'd0, nw >= 1}, 32'd1);
        end
        mode_wthru = 1'b0;
        for (int s = 0; s < 4; s++)
            for (int t = 0; t < 8; t++) begin
                do_op(1'b0, ad(t, s), 4'h0, 32'h0, rd, nr, nw);
                chk("R7", $sformatf("final read t%0d s%0d", t, s), rd, ref_m[ix(t, s)]);
            end

        finish_run();
    end

endmodule